// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block walks the register list of a compact 16-bit block-transfer instruction and turns it into a run of word accesses. It handles four operations: stack push, stack pop, store-multiple with ascending addresses and load-multiple with ascending addresses. The caller pulses `start` with the instruction word and the current value of the stack pointer or base register. The sequencer then issues one memory request per listed register, lowest register index first. It reads store data from the register file and writes load data back into it.

Each access carries a sequential/nonsequential marker. Stack operations may move one extra register: the link register on a push, the program counter on a pop. A push begins at the lowest address the whole frame will occupy, which is found from a population count of the list. Loads spend one idle cycle after their last access. When the sequence ends, `done` pulses for one cycle together with the stack-pointer or base writeback, and with a refill request when a pop has loaded the program counter.

Top module: `regxfer_seq`

## Requirements
- R1: With `start` high while idle, an instruction with bits 15:12 = 1011 and bits 10:9 = 10 is a stack operation: bit 11 = 1 means pop (load) and 0 means push (store), bit 8 adds the extra register, and bits 7:0 are the list. Bits 15:12 = 1100 select a multiple transfer: bit 11 = 1 means load and 0 means store, bits 10:8 give the base register, and bits 7:0 the list. `mem_we` is 1 for stores and 0 for loads. Any other encoding is ignored, and `busy` stays low.
- R2: A push starts at base minus 4 × (number of set list bits + extra bit). Pop and both multiple transfers start at the base value.
- R3: Listed registers are transferred in ascending index order, and the address rises by 4 on each accepted beat. The extra register comes last: register 14 is read on a push, and register 15 is written on a pop.
- R4: On stack operations the first listed access has `mem_seq` = 0 (nonsequential) and later listed accesses have `mem_seq` = 1 (sequential). The extra-register access has `mem_seq` = 0. Multiple transfers always drive `mem_seq` = 0.
- R5: A request holds its address and direction until `mem_ready`. During a store beat, `rf_raddr` is the beat's register and `mem_wdata` equals `rf_rdata`. A load beat asserts `rf_we` in its accepted cycle, with `rf_waddr` set to the beat's register and `rf_wdata` = `mem_rdata`.
- R6: With `done`, `wb_en` writes the final address to register 13 on stack operations, or to the base register on multiple transfers. The final address is base − 4·count on a push and base + 4·count otherwise. Writeback is suppressed on a load-multiple whose list contains the base register.
- R7: `done` rises two cycles after the cycle in which a load's last beat is accepted, and one cycle after a store's last beat.
- R8: `refill` pulses with `done` exactly when a pop loaded the program counter.
- R9: An empty list without an extra register makes no memory access. `done` comes in the cycle after acceptance, and there is no writeback.
- R10: `done` is high for one cycle. `busy` is high from the cycle after acceptance through the `done` cycle, and `start` is ignored while busy.
- R11: During and right after reset, `busy`, `done`, `mem_req`, `rf_we` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer with `instr` and `base_val` |
| instr | input | 16 | Instruction word |
| base_val | input | DATA_W | Stack pointer or base register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_addr | output | DATA_W | Request word address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seq | output | 1 | 1 = sequential, 0 = nonsequential |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data, valid with `mem_ready` |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| wb_en | output | 1 | Base / stack-pointer writeback enable |
| wb_addr | output | 4 | Writeback register index |
| wb_data | output | DATA_W | Writeback value |
| refill | output | 1 | Pipeline refill request after a program-counter load |

## Verification
The assertions assume that `mem_rdata` is valid in the cycle `mem_ready` is high. They also assume the register file answers a read in the same cycle, with no wait. The bench models both parts combinationally, as fixed functions of the address or index. It toggles `mem_ready` at random to stretch beats, and it changes `start` and `instr` only at the falling edge. Base values are word-aligned and kept well away from wrap-around, so the expected addresses are simple sums.

// File: rtl/regxfer_pkg.sv
// Shared types and helpers for the register-list transfer sequencer.
// Assumes an 8-bit register list and 16 architectural registers.
package regxfer_pkg;
    localparam int LIST_W    = 8;
    localparam int REG_IDX_W = 4;
    localparam int SP_IDX    = 13;
    localparam int LINK_IDX  = 14;
    localparam int PC_IDX    = 15;

    typedef enum logic [1:0] {K_PUSH, K_POP, K_STM, K_LDM} xfer_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL, S_FIN} seq_state_e;

    typedef struct packed {
        logic              valid;
        xfer_kind_e        kind;
        logic [LIST_W-1:0] list;
        logic              extra;
        logic [2:0]        base_reg;
    } xfer_decode_t;

    // Number of set bits in a register list.
    function automatic logic [REG_IDX_W-1:0] count_ones(input logic [LIST_W-1:0] v);
        logic [REG_IDX_W-1:0] n;
        n = '0;
        for (int i = 0; i < LIST_W; i++) n = n + REG_IDX_W'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/regxfer_decode.sv
// Instruction decoder and frame arithmetic.
// Purely combinational. Finds the operation kind, the total register count,
// the first beat address, the final writeback address and whether writeback
// is allowed. Assumes base_val is word aligned.
module regxfer_decode
    import regxfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [15:0]          instr,
    input  logic [DATA_W-1:0]    base_val,
    output xfer_decode_t         dec,
    output logic [REG_IDX_W-1:0] total,
    output logic [DATA_W-1:0]    first_addr,
    output logic [DATA_W-1:0]    final_addr,
    output logic                 wb_ok,
    output logic [REG_IDX_W-1:0] wb_idx
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic [DATA_W-1:0] span;

    // Field extraction for the two recognised encodings.
    always_comb begin
        dec = '0;
        if (instr[15:12] == 4'b1011 && instr[10:9] == 2'b10) begin
            dec.valid = 1'b1;
            dec.kind  = instr[11] ? K_POP : K_PUSH;
            dec.extra = instr[8];
            dec.list  = instr[7:0];
        end else if (instr[15:12] == 4'b1100) begin
            dec.valid    = 1'b1;
            dec.kind     = instr[11] ? K_LDM : K_STM;
            dec.base_reg = instr[10:8];
            dec.list     = instr[7:0];
        end
    end

    // Frame size, address bounds and writeback rules.
    always_comb begin
        total      = count_ones(dec.list) + REG_IDX_W'(dec.extra);
        span       = DATA_W'(total) * DATA_W'(WORD_BYTES);
        first_addr = (dec.kind == K_PUSH) ? base_val - span : base_val;
        final_addr = (dec.kind == K_PUSH) ? base_val - span : base_val + span;
        wb_ok      = dec.valid && (total != '0) &&
                     !(dec.kind == K_LDM && dec.list[dec.base_reg]);
        wb_idx     = (dec.kind == K_PUSH || dec.kind == K_POP) ?
                     REG_IDX_W'(SP_IDX) : REG_IDX_W'(dec.base_reg);
    end
endmodule

// File: rtl/regxfer_lowbit.sv
// Lowest-set-bit finder.
// Returns the index of the lowest set bit in mask and whether any bit is set.
// Assumes W is a power of two of at least 2.
module regxfer_lowbit #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/regxfer_seq.sv
// Register-list transfer sequencer (top).
// Accepts one push/pop/store-multiple/load-multiple instruction while idle.
// Issues one word beat per listed register in ascending order, then the
// optional extra register. Loads take one idle cycle after the last beat.
// Ends with a one-cycle done pulse carrying the writeback.
// Assumes rf_rdata is a same-cycle read of rf_raddr and that mem_rdata is
// valid whenever mem_ready is high.
module regxfer_seq
    import regxfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [15:0]          instr,
    input  logic [DATA_W-1:0]    base_val,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_req,
    input  logic                 mem_ready,
    output logic [DATA_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic                 mem_seq,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [REG_IDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_addr,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 refill
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LOW_W      = $clog2(LIST_W);

    xfer_decode_t         dec;
    logic [REG_IDX_W-1:0] total;
    logic [DATA_W-1:0]    first_addr, final_addr;
    logic                 wb_ok;
    logic [REG_IDX_W-1:0] wb_idx;

    seq_state_e           state_q;
    xfer_kind_e           kind_q;
    logic [LIST_W-1:0]    mask_q;
    logic                 extra_q, first_q, wb_ok_q, refill_q;
    logic [DATA_W-1:0]    addr_q, final_q;
    logic [REG_IDX_W-1:0] wb_idx_q;

    logic [LOW_W-1:0]     lo_idx;
    logic                 lo_any;
    logic [REG_IDX_W-1:0] cur_idx;
    logic                 is_load, is_stack, in_xfer, last_beat, accept, beat_ok;

    regxfer_decode #(.DATA_W(DATA_W)) u_decode (
        .instr      (instr),
        .base_val   (base_val),
        .dec        (dec),
        .total      (total),
        .first_addr (first_addr),
        .final_addr (final_addr),
        .wb_ok      (wb_ok),
        .wb_idx     (wb_idx)
    );

    regxfer_lowbit #(.W(LIST_W)) u_lowbit (
        .mask (mask_q),
        .idx  (lo_idx),
        .any  (lo_any)
    );

    // Current-beat selection and interface drive.
    always_comb begin
        is_load   = (kind_q == K_POP) || (kind_q == K_LDM);
        is_stack  = (kind_q == K_POP) || (kind_q == K_PUSH);
        in_xfer   = (state_q == S_XFER);
        cur_idx   = lo_any ? REG_IDX_W'(lo_idx) :
                    (kind_q == K_PUSH ? REG_IDX_W'(LINK_IDX) : REG_IDX_W'(PC_IDX));
        last_beat = lo_any ? (((mask_q & (mask_q - 1'b1)) == '0) && !extra_q) : 1'b1;
        accept    = (state_q == S_IDLE) && start && dec.valid;
        beat_ok   = in_xfer && mem_ready;

        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FIN);
        mem_req   = in_xfer;
        mem_addr  = addr_q;
        mem_we    = in_xfer && !is_load;
        mem_seq   = in_xfer && is_stack && lo_any && !first_q;
        mem_wdata = mem_we ? rf_rdata : '0;
        rf_raddr  = cur_idx;
        rf_we     = beat_ok && is_load;
        rf_waddr  = cur_idx;
        rf_wdata  = mem_rdata;
        wb_en     = done && wb_ok_q;
        wb_addr   = wb_idx_q;
        wb_data   = final_q;
        refill    = done && refill_q;
    end

    // Sequencer state: acceptance, beat advance, tail and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= K_PUSH;
            mask_q   <= '0;
            extra_q  <= 1'b0;
            first_q  <= 1'b0;
            wb_ok_q  <= 1'b0;
            refill_q <= 1'b0;
            addr_q   <= '0;
            final_q  <= '0;
            wb_idx_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        kind_q   <= dec.kind;
                        mask_q   <= dec.list;
                        extra_q  <= dec.extra;
                        first_q  <= 1'b1;
                        addr_q   <= first_addr;
                        final_q  <= final_addr;
                        wb_ok_q  <= wb_ok;
                        wb_idx_q <= wb_idx;
                        refill_q <= (dec.kind == K_POP) && dec.extra;
                        state_q  <= (total == '0) ? S_FIN : S_XFER;
                    end
                end
                S_XFER: begin
                    if (beat_ok) begin
                        addr_q  <= addr_q + DATA_W'(WORD_BYTES);
                        first_q <= 1'b0;
                        if (lo_any) mask_q  <= mask_q & (mask_q - 1'b1);
                        else        extra_q <= 1'b0;
                        if (last_beat) state_q <= is_load ? S_TAIL : S_FIN;
                    end
                end
                S_TAIL:  state_q <= S_FIN;
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regxfer_seq_chk.sv
// Protocol checker for regxfer_seq, attached by bind.
// Assumes the memory side may hold mem_ready low for any number of cycles.
module regxfer_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_seq,
    input logic              rf_we,
    input logic              wb_en,
    input logic              refill
);
    localparam int WORD_BYTES = DATA_W / 8;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + DATA_W'(WORD_BYTES))); // R3
    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_req && mem_ready && !mem_we); // R5
    AST_SEQ_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_seq |-> mem_req); // R4
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R6
    AST_LOAD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we |=> !done); // R7
    AST_REFILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        refill |-> done && !mem_req); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !mem_req); // R10
endmodule

bind regxfer_seq regxfer_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_seq(mem_seq), .rf_we(rf_we), .wb_en(wb_en), .refill(refill)
);

// File: tb/tb_regxfer_seq.sv
`timescale 1ns/1ps
// Bench for regxfer_seq: random and directed transfers against a reference model.
module tb_regxfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] base_val = '0;
    logic        busy, done, mem_req, mem_we, mem_seq, rf_we, wb_en, refill;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, wb_data;
    logic [3:0]  rf_raddr, rf_waddr, wb_addr;

    int checks = 0;
    int failures = 0;

    int          e_n;
    int          e_idx [9];
    logic [31:0] e_addr [9];
    logic        e_seq [9];
    logic        e_load, e_wbok, e_refill;
    logic [3:0]  e_wbidx;
    logic [31:0] e_final;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [3:0] i);
        return 32'h1000_0000 + {28'd0, i} * 32'h0011_0003;
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'hDEAD_BEEF;
    endfunction

    assign rf_rdata  = rf_val(rf_raddr);
    assign mem_rdata = mem_val(mem_addr);

    regxfer_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base_val(base_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_seq(mem_seq), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .wb_en(wb_en), .wb_addr(wb_addr),
        .wb_data(wb_data), .refill(refill)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic build_expect(input logic [15:0] ins, input logic [31:0] base);
        logic stack, ext, first;
        logic [2:0] rn;
        logic [31:0] a;
        int cnt;
        stack = (ins[15:12] == 4'b1011);
        e_load = ins[11];
        ext = stack ? ins[8] : 1'b0;
        rn = stack ? 3'd0 : ins[10:8];
        cnt = ext ? 1 : 0;
        for (int i = 0; i < 8; i++) if (ins[i]) cnt++;
        a = (stack && !e_load) ? base - 32'(cnt * 4) : base;
        e_n = 0;
        first = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (ins[i]) begin
                e_idx[e_n] = i; e_addr[e_n] = a; e_seq[e_n] = stack && !first;
                first = 1'b0; a = a + 32'd4; e_n++;
            end
        end
        if (ext) begin
            e_idx[e_n] = e_load ? 15 : 14; e_addr[e_n] = a; e_seq[e_n] = 1'b0; e_n++;
        end
        e_final  = (stack && !e_load) ? base - 32'(cnt * 4) : base + 32'(cnt * 4);
        e_wbok   = (cnt != 0) && !(!stack && e_load && ins[rn]);
        e_wbidx  = stack ? 4'd13 : {1'b0, rn};
        e_refill = stack && e_load && ext;
    endtask

    // One transfer; ready_mode 1 = always ready, 0 = random; poke pulses start mid-run.
    task automatic run_op(input logic [15:0] ins, input logic [31:0] base,
                          input bit ready_mode, input bit poke);
        int b, cyc, last_cyc;
        bit got_done;
        build_expect(ins, base);
        @(negedge clk);
        instr = ins; base_val = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        b = 0; cyc = 0; last_cyc = -1; got_done = 1'b0;
        while (!got_done && cyc < 200) begin
            mem_ready = ready_mode ? 1'b1 : 1'($urandom % 2);
            if (poke && cyc == 0) begin start = 1'b1; instr = 16'hB5FF; end
            else begin start = 1'b0; instr = ins; end
            #1;
            chk(busy == 1'b1, "R10", "busy during run", 32'(busy), 32'd1);
            if (mem_req) begin
                if (b >= e_n) chk(1'b0, "R9", "unexpected beat", 32'(b), 32'(e_n));
                else begin
                    chk(mem_addr == e_addr[b], b == 0 ? "R2" : "R3", "beat addr", mem_addr, e_addr[b]);
                    chk(mem_we == !e_load, "R1", "beat direction", 32'(mem_we), 32'(!e_load));
                    chk(mem_seq == e_seq[b], "R4", "seq marker", 32'(mem_seq), 32'(e_seq[b]));
                    if (!e_load) begin
                        chk(rf_raddr == 4'(e_idx[b]), "R3", "store reg", 32'(rf_raddr), 32'(e_idx[b]));
                        chk(mem_wdata == rf_val(4'(e_idx[b])), "R5", "store data", mem_wdata, rf_val(4'(e_idx[b])));
                    end else if (mem_ready) begin
                        chk(rf_we && rf_waddr == 4'(e_idx[b]), "R3", "load reg", 32'(rf_waddr), 32'(e_idx[b]));
                        chk(rf_wdata == mem_val(e_addr[b]), "R5", "load data", rf_wdata, mem_val(e_addr[b]));
                    end
                    if (mem_ready) begin b++; last_cyc = cyc; end
                end
            end
            if (done) begin
                got_done = 1'b1;
                chk(b == e_n, "R3", "beat count", 32'(b), 32'(e_n));
                if (e_n == 0) chk(cyc == 0, "R9", "empty latency", 32'(cyc), 32'd0);
                else chk(cyc - last_cyc == (e_load ? 2 : 1), "R7", "done latency",
                         32'(cyc - last_cyc), e_load ? 32'd2 : 32'd1);
                chk(wb_en == e_wbok, "R6", "wb enable", 32'(wb_en), 32'(e_wbok));
                if (e_wbok) begin
                    chk(wb_addr == e_wbidx, "R6", "wb index", 32'(wb_addr), 32'(e_wbidx));
                    chk(wb_data == e_final, "R6", "wb value", wb_data, e_final);
                end
                chk(refill == e_refill, "R8", "refill", 32'(refill), 32'(e_refill));
            end
            cyc++;
            @(negedge clk);
        end
        if (!got_done) chk(1'b0, "R10", "no done", 32'(cyc), 32'd0);
        start = 1'b0; mem_ready = 1'b0;
        #1;
        chk(!busy && !done, "R10", "idle after done", 32'(busy), 32'd0);
    endtask

    task automatic try_invalid(input logic [15:0] ins);
        @(negedge clk);
        instr = ins; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(!busy && !mem_req, "R1", "invalid encoding ignored", 32'(busy), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !mem_req && !rf_we && !wb_en, "R11", "reset outputs",
            {27'd0, busy, done, mem_req, rf_we, wb_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !mem_req, "R11", "after reset", 32'(busy), 32'd0);

        // Directed corner cases.
        run_op(16'hB5FF, 32'h0000_8000, 1'b1, 1'b0); // push all + link
        run_op(16'hBDFF, 32'h0000_8000, 1'b0, 1'b0); // pop all + PC
        run_op(16'hBD00, 32'h0000_4000, 1'b1, 1'b0); // pop of PC only
        run_op(16'hB400, 32'h0000_4000, 1'b1, 1'b0); // R9 empty push
        run_op(16'hCB00, 32'h0000_4000, 1'b1, 1'b0); // R9 empty load-multiple
        run_op(16'hCA0C, 32'h0000_2000, 1'b0, 1'b0); // load-multiple, base r2 in list
        run_op(16'hCA09, 32'h0000_2000, 1'b1, 1'b0); // load-multiple, base r2 not in list
        run_op(16'hC3A5, 32'h0000_3000, 1'b0, 1'b1); // R10 store-multiple, start poked while busy
        run_op(16'hB481, 32'h0000_6000, 1'b1, 1'b1); // push r0,r7 with poke
        try_invalid(16'h0000);
        try_invalid(16'hB000);
        try_invalid(16'hB6FF);

        // Random mix.
        for (int k = 0; k < 300; k++) begin
            logic [15:0] ins;
            logic [7:0] lst;
            lst = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
            if ($urandom % 2 == 0)
                ins = {4'b1011, 1'($urandom), 2'b10, 1'($urandom), lst};
            else
                ins = {4'b1100, 1'($urandom), 3'($urandom), lst};
            run_op(ins, {12'h000, 18'($urandom), 2'b00} + 32'h0000_1000,
                   1'($urandom % 3 == 0), 1'($urandom % 4 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule